// File: doc/BRIEF.md
# Circular packet receive buffer

This block sits between a receive MAC and a host. Frame bytes arrive one per beat with start, end and good/bad markers. They are written into a 4096-byte store that wraps around. A small queue of up to eight descriptors records, for each finished frame, where it begins in the store, how many bytes it holds and whether it was received without error. A one-cycle interrupt pulse tells the host that a frame has been stored.

The host works through a small register port. It can see the oldest unreleased frame (the current frame): its valid and good flags, its length and its start address. It can stream that frame out one byte per read, or peek at any byte at an offset from the frame's start. When it is done, it gives the descriptor back with a skip or a clear-valid command. Skipped bytes stay in the store until later frames write over them. An inhibit bit stops new frames from being accepted. A frame that finds all descriptors busy, or that would write over bytes still held by an unreleased frame, is thrown away and raises a sticky overflow flag.

Top module: `pkt_rx_buffer`

## Requirements
- R1: The store holds 4096 bytes and every address wraps modulo 4096, so a frame may start near the top of the store and continue at address 0. When it is read back, its bytes come out in arrival order.
- R2: At most 8 frames are held. A start beat that arrives while 8 are held drops the whole frame without an interrupt and sets the overflow flag (bit 5 of the status register at address 0).
- R3: The current frame's descriptor can be read at these addresses: length high byte at 1, length low byte at 2, start address high byte at 3, start address low byte at 4. Frames are placed back to back, each starting where the last stored frame ended.
- R4: The beat carrying a frame's end byte makes `irq` high in the following cycle, and only in that cycle.
- R5: Each read of address 5 returns the next byte of the current frame, beginning with its first byte. Register reads return their data one cycle after `reg_rd`.
- R6: The status register at address 0 reads {valid, good, overflow, inhibit, count[3:0]} from bit 7 down to bit 0. It is 0x00 after reset. Writing control address 9 with bit 0 set (skip) releases the current frame, and the next stored frame becomes current.
- R7: Writing control address 9 with bit 1 set (clear-valid) also releases the current frame.
- R8: Addresses 7 and 8 hold a 16-bit peek offset (high byte, low byte). A read of address 6 returns the byte at the current frame's start plus that offset, modulo 4096.
- R9: Every write to address 9 loads the inhibit flag from bit 2. While inhibit is 1, frames are dropped without an interrupt and without setting overflow.
- R10: A frame that would write over bytes of an unreleased frame is dropped without an interrupt and sets overflow. The write position stays where it was, so the next frame starts where the last stored frame ended.
- R11: A frame whose end beat has the good flag at 0 is still stored, and its descriptor reports good = 0.
- R12: When a release and a frame commit fall in the same cycle, both take effect: the count stays the same and the new frame is queued behind the next one.
- R13: Writing address 9 with bit 3 set clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_good | input | 1 | Frame received without error (sampled with rx_eof) |
| rx_data | input | 8 | Frame byte |
| reg_rd | input | 1 | Host register read strobe |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, valid one cycle after reg_rd |
| irq | output | 1 | One-cycle pulse when a frame has been stored |

## Verification
A frame commit on the MAC side and a descriptor release on the host side can land in the same clock cycle. Both change the frame count, the byte occupancy and the queue pointers. The bench sets this up by forking a frame sender against a skip write timed to hit the frame's end beat. It then checks that the count has not changed, and that the newly stored frame becomes current with the length and start address it should have.

// File: rtl/pkt_rx_buffer.sv
module pkt_rx_buffer #(
  parameter int DEPTH = 4096,
  parameter int SLOTS = 8,
  parameter int LW    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic       rx_sof,
  input  logic       rx_eof,
  input  logic       rx_good,
  input  logic [7:0] rx_data,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(SLOTS);
  localparam int CW = SW + 1;
  localparam logic [3:0] A_STAT = 4'd0, A_LENH = 4'd1, A_LENL = 4'd2, A_STH = 4'd3,
                         A_STL = 4'd4, A_AUTO = 4'd5, A_PEEK = 4'd6, A_OFFH = 4'd7,
                         A_OFFL = 4'd8, A_CTRL = 4'd9;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] d_start [SLOTS];
  logic [LW-1:0] d_len [SLOTS];
  logic [SLOTS-1:0] d_ok;
  logic [SW-1:0] head, tail;
  logic [CW-1:0] count;
  logic [AW:0]   held, w_len;
  logic [AW-1:0] wr_ptr, w_addr, f_start, rd_off;
  logic          in_frame, inhibit, ovf;
  logic [15:0]   peek_off;

  wire ctrl_wr     = reg_wr && reg_addr == A_CTRL;
  wire release_pkt = ctrl_wr && (reg_wdata[0] || reg_wdata[1]) && count != '0;
  wire full        = count == CW'(SLOTS);
  wire sof_ok      = rx_sof && !inhibit && !full;
  wire active      = rx_valid && (rx_sof ? sof_ok : in_frame);
  wire [AW-1:0] b_addr  = rx_sof ? wr_ptr : w_addr;
  wire [AW:0]   b_len   = rx_sof ? '0 : w_len;
  wire [AW-1:0] b_start = rx_sof ? wr_ptr : f_start;
  wire room   = ({1'b0, held} + {1'b0, b_len}) < (AW+2)'(DEPTH);
  wire wr_en  = active && room;
  wire commit = wr_en && rx_eof;
  wire [AW:0]   n_len     = b_len + 1'b1;
  wire [AW-1:0] cur_start = d_start[head];
  wire [LW-1:0] cur_len   = d_len[head];
  wire [15:0]   len16     = 16'(cur_len);
  wire [15:0]   st16      = 16'(cur_start);

  always_ff @(posedge clk)
    if (wr_en) mem[b_addr] <= rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0; w_addr <= '0; w_len <= '0; f_start <= '0;
      wr_ptr <= '0; held <= '0; count <= '0; head <= '0; tail <= '0;
      d_ok <= '0; ovf <= 1'b0; inhibit <= 1'b0; irq <= 1'b0;
    end else begin
      irq <= commit;
      if (ctrl_wr) begin
        inhibit <= reg_wdata[2];
        if (reg_wdata[3]) ovf <= 1'b0;
      end
      if (rx_valid && rx_sof && !inhibit && full) ovf <= 1'b1;
      if (rx_valid && rx_sof && !sof_ok) in_frame <= 1'b0;
      if (active && !room) begin
        in_frame <= 1'b0;
        ovf <= 1'b1;
      end
      if (wr_en) begin
        if (rx_eof) begin
          d_start[tail] <= b_start;
          d_len[tail]   <= LW'(n_len);
          d_ok[tail]    <= rx_good;
          tail     <= tail + 1'b1;
          wr_ptr   <= b_addr + 1'b1;
          in_frame <= 1'b0;
        end else begin
          in_frame <= 1'b1;
          w_addr   <= b_addr + 1'b1;
          w_len    <= n_len;
          f_start  <= b_start;
        end
      end
      if (release_pkt) head <= head + 1'b1;
      count <= count + CW'(commit) - CW'(release_pkt);
      held  <= held + (commit ? n_len : '0) - (release_pkt ? (AW+1)'(cur_len) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0; rd_off <= '0; peek_off <= '0;
    end else begin
      if (reg_wr && reg_addr == A_OFFH) peek_off[15:8] <= reg_wdata;
      if (reg_wr && reg_addr == A_OFFL) peek_off[7:0]  <= reg_wdata;
      if (release_pkt) rd_off <= '0;
      else if (reg_rd && reg_addr == A_AUTO) rd_off <= rd_off + 1'b1;
      if (reg_rd)
        case (reg_addr)
          A_STAT:  reg_rdata <= {count != '0, d_ok[head] && count != '0, ovf, inhibit, 4'(count)};
          A_LENH:  reg_rdata <= len16[15:8];
          A_LENL:  reg_rdata <= len16[7:0];
          A_STH:   reg_rdata <= st16[15:8];
          A_STL:   reg_rdata <= st16[7:0];
          A_AUTO:  reg_rdata <= mem[cur_start + rd_off];
          A_PEEK:  reg_rdata <= mem[cur_start + peek_off[AW-1:0]];
          A_OFFH:  reg_rdata <= peek_off[15:8];
          A_OFFL:  reg_rdata <= peek_off[7:0];
          default: reg_rdata <= '0;
        endcase
    end
  end

  // R2: never more than SLOTS descriptors held
  p_count_max_r2: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(SLOTS));
  // R10: held bytes never exceed the store
  p_held_bound_r10: assert property (@(posedge clk) disable iff (!rst_n) held <= (AW+1)'(DEPTH));
  // R4: interrupt only after an end beat
  p_irq_eof_r4: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(rx_valid && rx_eof));
  // R2: start beat while full is dropped and flagged
  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof && !inhibit && full) |=> (ovf && !irq));
  // R9: inhibited start beat never commits and leaves overflow alone
  p_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof && inhibit && !ovf && !ctrl_wr) |=> (!irq && !ovf));
  // R5: auto-read advances the read offset by one
  p_auto_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_AUTO && !release_pkt) |=> rd_off == AW'($past(rd_off) + 1'b1));
  // R12: release plus commit in one cycle keeps the count
  p_both_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (release_pkt && commit) |=> $stable(count));
endmodule

// File: tb/tb_pkt_rx_buffer.sv
module tb_pkt_rx_buffer;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_good = 0;
  logic [7:0] rx_data = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  pkt_rx_buffer dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bf(logic [7:0] seed, int i);
    return 8'(seed + i * 7);
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (reg_rd) begin
    #1;
    if (exp_q.size() > 0) chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic rd_reg(logic [3:0] a, logic [7:0] exp, string tag);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wr_reg(logic [3:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic send_frame(int len, logic [7:0] seed, bit good, bit exp_irq, string tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_good = good; rx_data = bf(seed, i);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
    chk({7'b0, irq}, {7'b0, exp_irq}, tag);
    @(negedge clk);
    chk({7'b0, irq}, 8'h00, "R4 irq lasts one cycle");
  endtask

  task automatic auto_read(int len, logic [7:0] seed, string tag);
    for (int i = 0; i < len; i++) rd_reg(4'd5, bf(seed, i), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk({7'b0, irq}, 8'h00, "R4 irq after reset");
    rd_reg(4'd0, 8'h00, "R6 status after reset");

    send_frame(5, 8'h10, 1, 1, "R4 irq after frame A");
    rd_reg(4'd0, 8'hC1, "R6 status one good frame");
    rd_reg(4'd1, 8'h00, "R3 len hi A");
    rd_reg(4'd2, 8'h05, "R3 len lo A");
    rd_reg(4'd3, 8'h00, "R3 start hi A");
    rd_reg(4'd4, 8'h00, "R3 start lo A");
    auto_read(5, 8'h10, "R5 autoread A");
    wr_reg(4'd9, 8'h02);
    rd_reg(4'd0, 8'h00, "R7 clear-valid releases");

    send_frame(4, 8'h20, 0, 1, "R4 irq after bad frame");
    rd_reg(4'd0, 8'h81, "R11 bad frame stored, good=0");
    rd_reg(4'd4, 8'h05, "R3 start lo follows A");
    wr_reg(4'd7, 8'h00); wr_reg(4'd8, 8'h02);
    rd_reg(4'd6, bf(8'h20, 2), "R8 peek offset 2");
    wr_reg(4'd9, 8'h01);
    rd_reg(4'd0, 8'h00, "R6 skip releases");

    wr_reg(4'd9, 8'h04);
    send_frame(6, 8'h30, 1, 0, "R9 inhibited frame no irq");
    rd_reg(4'd0, 8'h10, "R9 inhibited frame dropped, no overflow");
    wr_reg(4'd9, 8'h00);

    for (int k = 0; k < 8; k++) send_frame(3, 8'(8'h40 + k * 16), 1, 1, "R2 fill irq");
    rd_reg(4'd0, 8'hC8, "R2 eight held");
    send_frame(3, 8'hEE, 1, 0, "R2 ninth frame no irq");
    rd_reg(4'd0, 8'hE8, "R2 ninth dropped, overflow");
    wr_reg(4'd9, 8'h08);
    rd_reg(4'd0, 8'hC8, "R13 overflow cleared");
    rd_reg(4'd4, 8'h09, "R3 first filled start");
    auto_read(3, 8'h40, "R5 autoread filled frame 0");
    wr_reg(4'd9, 8'h02);
    rd_reg(4'd4, 8'h0C, "R6 next frame current");
    auto_read(3, 8'h50, "R5 autoread filled frame 1");
    for (int k = 0; k < 7; k++) wr_reg(4'd9, 8'h01);
    rd_reg(4'd0, 8'h00, "R6 all released");

    send_frame(6, 8'h60, 1, 1, "R4 frame P");
    fork
      send_frame(4, 8'h70, 1, 1, "R12 frame Q irq");
      begin repeat (3) @(negedge clk); wr_reg(4'd9, 8'h01); end
    join
    rd_reg(4'd0, 8'hC1, "R12 count kept at one");
    rd_reg(4'd2, 8'h04, "R12 Q is current, len");
    rd_reg(4'd4, 8'h27, "R12 Q is current, start");
    auto_read(4, 8'h70, "R12 Q data");
    wr_reg(4'd9, 8'h01);

    send_frame(4000, 8'h05, 1, 1, "R4 big frame");
    rd_reg(4'd1, 8'h0F, "R3 big len hi");
    rd_reg(4'd2, 8'hA0, "R3 big len lo");
    send_frame(200, 8'h99, 1, 0, "R10 overwrite frame no irq");
    rd_reg(4'd0, 8'hE1, "R10 overwrite dropped, overflow");
    wr_reg(4'd9, 8'h08);
    wr_reg(4'd9, 8'h01);
    rd_reg(4'd0, 8'h00, "R6 big frame skipped");

    send_frame(100, 8'h33, 1, 1, "R4 wrap frame");
    rd_reg(4'd3, 8'h0F, "R10 start hi unchanged after drop");
    rd_reg(4'd4, 8'hCB, "R10 start lo unchanged after drop");
    wr_reg(4'd7, 8'h00); wr_reg(4'd8, 8'd60);
    rd_reg(4'd6, bf(8'h33, 60), "R8 peek across wrap");
    auto_read(100, 8'h33, "R1 wrapped data order");
    wr_reg(4'd9, 8'h02);
    rd_reg(4'd0, 8'h00, "R7 wrap frame released");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule